// File: doc/BRIEF.md
# Double-Buffered Timer PWM Output

This block drives one pulse-width-modulated output from an up-counter that runs on the input clock. Software sets it up through a small synchronous register bus. There are four 32-bit value registers: the live period and live compare, plus a staged copy of each. There is also a 16-bit control word. The counter climbs from zero to the live period, then returns to zero. The output level depends on whether the count is below the live compare value. A polarity bit inverts that level.

While the counter is stopped, software writes the live period and compare directly. While it runs, software writes the staged copies instead. Staged values move into the live registers only on the cycle the counter returns to zero, so the period in progress always completes with the settings it started with. One control bit enables the output; when this bit is clear the pin is held low. A separate control bit lets the counter run.

Top module: `shpwm_top`

## Requirements
- R1: After reset the output is low and the count is 0. Every register reads 0 and the counter stays stopped.
- R2: Byte addresses are 0x08 live period, 0x0C live compare, 0x10 staged period and 0x14 staged compare. The 16-bit control word is at 0x2A, which is bits 31:16 of the word at 0x28. In the control word, bit 4 is run, bit 9 is output enable, bit 10 is polarity, and bits 7:6 are the sync-disable pair. These bits read back as written; every other control bit reads 0.
- R3: Each of the four byte strobes writes only its own byte lane. A control-word write with only strobes 1:0 set changes nothing.
- R4: When run is set, the count rises by one per clock. On the clock after the count equals the live period, the count is 0. When run is clear, the count holds its value.
- R5: With output enabled and polarity 0, the output is high exactly while the count is below the live compare value.
- R6: With output enable clear, the output is low whatever the count and settings.
- R7: With polarity 1, the output is the inverse of its polarity-0 level: low while the count is below the compare value.
- R8: A compare of 0 gives a constant inactive level. A compare equal to or above the period gives a constant active level.
- R9: Writes to the live period and compare take effect on the next clock while run is clear. While run is set, these writes are ignored.
- R10: Staged writes leave the current period unchanged. They are copied into the live registers on the clock where the count returns to 0, and only if a staged write has occurred since the last copy. A staged register reads back its last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 1 | Modulated output |
| count_o | output | CNT_W | Current counter value |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and a 6-bit byte address. Periods of only a few counts still exercise every wrap, staged copy and constant-level corner within a few dozen cycles. The full 32-bit register width means that byte-lane merging on the upper bytes can be seen on readback.

// File: rtl/shpwm_pkg.sv
package shpwm_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  localparam logic [7:0] OFF_LIVE_PRD = 8'h08;
  localparam logic [7:0] OFF_LIVE_CMP = 8'h0C;
  localparam logic [7:0] OFF_STG_PRD  = 8'h10;
  localparam logic [7:0] OFF_STG_CMP  = 8'h14;
  localparam logic [7:0] OFF_CTL_WORD = 8'h28;

  localparam int CTL_RUN  = 4;
  localparam int CTL_SYN0 = 6;
  localparam int CTL_SYN1 = 7;
  localparam int CTL_EN   = 9;
  localparam int CTL_POL  = 10;
  localparam logic [15:0] CTL_KEEP = 16'h06D0;

  function automatic logic [BUS_W-1:0] merge_lanes(
    input logic [BUS_W-1:0] old_v,
    input logic [BUS_W-1:0] new_v,
    input logic [LANES-1:0] be
  );
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic active_level(
    input logic [31:0] cnt,
    input logic [31:0] cmp,
    input logic [31:0] prd
  );
    return (cnt < cmp) || (cmp >= prd && cmp != 32'd0);
  endfunction

  function automatic logic pin_level(
    input logic        en,
    input logic        pol,
    input logic [31:0] cnt,
    input logic [31:0] cmp,
    input logic [31:0] prd
  );
    logic a;
    a = active_level(cnt, cmp, prd);
    return en & (pol ? ~a : a);
  endfunction
endpackage

// File: rtl/shpwm_counter.sv
module shpwm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = run && (cnt_q == prd);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/shpwm_regs.sv
module shpwm_regs
  import shpwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              wrap,
  output logic              run,
  output logic              out_en,
  output logic              pol,
  output logic              pend,
  output logic [CNT_W-1:0]  live_prd,
  output logic [CNT_W-1:0]  live_cmp,
  output logic [CNT_W-1:0]  stg_prd,
  output logic [CNT_W-1:0]  stg_cmp
);
  localparam int PADW = BUS_W - CNT_W;

  logic [15:0]      ctl_q;
  logic [CNT_W-1:0] lprd_q, lcmp_q, sprd_q, scmp_q;
  logic             pend_q;

  logic hit_lprd, hit_lcmp, hit_sprd, hit_scmp, hit_ctl;
  logic wr_live_ok, stg_wr;
  logic [BUS_W-1:0] ctl_word, ctl_merged;

  assign hit_lprd = bus_addr == ADDR_W'(OFF_LIVE_PRD);
  assign hit_lcmp = bus_addr == ADDR_W'(OFF_LIVE_CMP);
  assign hit_sprd = bus_addr == ADDR_W'(OFF_STG_PRD);
  assign hit_scmp = bus_addr == ADDR_W'(OFF_STG_CMP);
  assign hit_ctl  = bus_addr == ADDR_W'(OFF_CTL_WORD);

  assign wr_live_ok = bus_wr && !ctl_q[CTL_RUN];
  assign stg_wr     = bus_wr && (hit_sprd || hit_scmp);
  assign ctl_word   = {ctl_q, 16'h0000};
  assign ctl_merged = merge_lanes(ctl_word, bus_wdata, bus_be);

  function automatic logic [BUS_W-1:0] widen(input logic [CNT_W-1:0] v);
    return {{PADW{1'b0}}, v};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (bus_wr && hit_ctl) begin
      ctl_q <= ctl_merged[31:16] & CTL_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sprd_q <= '0;
      scmp_q <= '0;
    end else begin
      if (bus_wr && hit_sprd) sprd_q <= CNT_W'(merge_lanes(widen(sprd_q), bus_wdata, bus_be));
      if (bus_wr && hit_scmp) scmp_q <= CNT_W'(merge_lanes(widen(scmp_q), bus_wdata, bus_be));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (stg_wr) begin
      pend_q <= 1'b1;
    end else if (wrap) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lprd_q <= '0;
      lcmp_q <= '0;
    end else if (wrap && pend_q) begin
      lprd_q <= sprd_q;
      lcmp_q <= scmp_q;
    end else begin
      if (wr_live_ok && hit_lprd) lprd_q <= CNT_W'(merge_lanes(widen(lprd_q), bus_wdata, bus_be));
      if (wr_live_ok && hit_lcmp) lcmp_q <= CNT_W'(merge_lanes(widen(lcmp_q), bus_wdata, bus_be));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_lprd) bus_rdata = widen(lprd_q);
    if (hit_lcmp) bus_rdata = widen(lcmp_q);
    if (hit_sprd) bus_rdata = widen(sprd_q);
    if (hit_scmp) bus_rdata = widen(scmp_q);
    if (hit_ctl)  bus_rdata = ctl_word;
  end

  assign run      = ctl_q[CTL_RUN];
  assign out_en   = ctl_q[CTL_EN];
  assign pol      = ctl_q[CTL_POL];
  assign pend     = pend_q;
  assign live_prd = lprd_q;
  assign live_cmp = lcmp_q;
  assign stg_prd  = sprd_q;
  assign stg_cmp  = scmp_q;
endmodule

// File: rtl/shpwm_outgen.sv
module shpwm_outgen
  import shpwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             out_en,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] prd,
  output logic             pin
);
  assign pin = pin_level(out_en, pol, 32'(cnt), 32'(cmp), 32'(prd));
endmodule

// File: rtl/shpwm_top.sv
module shpwm_top
  import shpwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             run_w, en_w, pol_w, pend_w, wrap_w;
  logic [CNT_W-1:0] cnt_w, prd_w, cmp_w, sprd_w, scmp_w;

  shpwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap(wrap_w), .run(run_w), .out_en(en_w), .pol(pol_w), .pend(pend_w),
    .live_prd(prd_w), .live_cmp(cmp_w), .stg_prd(sprd_w), .stg_cmp(scmp_w)
  );

  shpwm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .prd(prd_w),
    .cnt(cnt_w), .wrap(wrap_w)
  );

  shpwm_outgen #(.CNT_W(CNT_W)) out_i (
    .out_en(en_w), .pol(pol_w), .cnt(cnt_w), .cmp(cmp_w), .prd(prd_w),
    .pin(pwm_o)
  );

  assign count_o = cnt_w;
endmodule

// File: rtl/shpwm_chk.sv
module shpwm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             en,
  input logic             pol,
  input logic             pend,
  input logic             wrap,
  input logic             pwm,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] sprd,
  input logic [CNT_W-1:0] scmp
);
  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == prd) |=> cnt == '0);

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != prd) |=> cnt == $past(cnt) + CNT_W'(1));

  // R6
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm);

  // R5
  normal_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pol && cnt < cmp) |-> pwm);

  // R7
  invert_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pol && cnt < cmp) |-> !pwm);

  // R8
  zero_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmp == '0) |-> pwm == pol);

  // R10
  stage_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && pend) |=> (prd == $past(sprd) && cmp == $past(scmp)));

  // R9
  live_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(prd) && $stable(cmp)));
endmodule

bind shpwm_top shpwm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_w), .en(en_w), .pol(pol_w),
  .pend(pend_w), .wrap(wrap_w), .pwm(pwm_o), .cnt(cnt_w),
  .prd(prd_w), .cmp(cmp_w), .sprd(sprd_w), .scmp(scmp_w)
);

// File: tb/shpwm_tb.sv
module shpwm_top_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_be = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          pwm_o;
  logic [31:0]   count_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench-side expectation
  logic [31:0] m_cnt, m_prd, m_cmp, m_sprd, m_scmp;
  logic        m_run, m_en, m_pol, m_pend;

  always #(CLK_NS/2) clk = ~clk;

  shpwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o), .count_o(count_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0; m_prd = 0; m_cmp = 0; m_sprd = 0; m_scmp = 0;
    m_run = 0; m_en = 0; m_pol = 0; m_pend = 0;
  endtask

  function automatic logic exp_pin();
    logic act;
    act = (m_cnt < m_cmp) || (m_cmp != 0 && m_cmp >= m_prd);
    return m_en & (m_pol ^ act);
  endfunction

  // one clock: check outputs, optionally write, advance the expectation
  task automatic step(input string req, input bit wr, input logic [7:0] a,
                      input logic [31:0] d);
    bit wrapping;
    check(req, "count", count_o, m_cnt);
    check(req, "pin", {31'd0, pwm_o}, {31'd0, exp_pin()});
    bus_addr = a[AW-1:0]; bus_wr = wr; bus_wdata = d;
    bus_be = (a == 8'h28) ? 4'hC : 4'hF;
    wrapping = m_run && (m_cnt == m_prd);
    if (m_run) m_cnt = wrapping ? 0 : m_cnt + 1;
    if (wrapping && m_pend) begin
      m_prd = m_sprd; m_cmp = m_scmp; m_pend = 0;
    end
    if (wr) begin
      case (a)
        8'h08: if (!m_run) m_prd = d;
        8'h0C: if (!m_run) m_cmp = d;
        8'h10: begin m_sprd = d; m_pend = 1; end
        8'h14: begin m_scmp = d; m_pend = 1; end
        8'h28: begin m_run = d[20]; m_en = d[25]; m_pol = d[26]; end
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, 0, 8'h00, 0);
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a[AW-1:0]; bus_wr = 1'b1; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a[AW-1:0];
    #1;
    check(req, $sformatf("read %h", a), bus_rdata, exp);
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit en, input bit pol);
    logic [15:0] c;
    c = '0; c[4] = run; c[9] = en; c[10] = pol;
    return {c, 16'h0};
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1", "pin", {31'd0, pwm_o}, 0);
    check("R1", "count", count_o, 0);
    rd("R1", 8'h08, 0); rd("R1", 8'h0C, 0); rd("R1", 8'h10, 0);
    rd("R1", 8'h14, 0); rd("R1", 8'h28, 0);
    idle("R1", 3);
  endtask

  task automatic t_map();
    do_reset();
    wr_raw(8'h08, 32'h1111_0008, 4'hF);
    wr_raw(8'h0C, 32'h2222_000C, 4'hF);
    wr_raw(8'h10, 32'h3333_0010, 4'hF);
    wr_raw(8'h14, 32'h4444_0014, 4'hF);
    wr_raw(8'h28, 32'hFFFF_0000 & ~32'h0010_0000, 4'hC);
    rd("R2", 8'h08, 32'h1111_0008); rd("R2", 8'h0C, 32'h2222_000C);
    rd("R2", 8'h10, 32'h3333_0010); rd("R2", 8'h14, 32'h4444_0014);
    rd("R2", 8'h28, 32'h06C0_0000);
    check("R2", "count held with run clear", count_o, 0);
  endtask

  task automatic t_lanes();
    do_reset();
    wr_raw(8'h08, 32'hFFFF_FFFF, 4'hF);
    wr_raw(8'h08, 32'h1122_3344, 4'b0101);
    rd("R3", 8'h08, 32'hFF22_FF44);
    wr_raw(8'h28, 32'hFFFF_FFFF, 4'b0011);
    rd("R3", 8'h28, 32'h0);
    wr_raw(8'h28, 32'h0400_0000, 4'b1000);
    rd("R3", 8'h28, 32'h0400_0000);
  endtask

  task automatic t_count();
    do_reset();
    step("R4", 1, 8'h08, 4);
    step("R4", 1, 8'h0C, 2);
    step("R4", 1, 8'h28, ctl(1, 1, 0));
    idle("R4", 12);
    step("R4", 1, 8'h28, ctl(0, 1, 0));
    idle("R4", 5);
  endtask

  task automatic t_wave(input string req, input logic [31:0] p,
                        input logic [31:0] c, input bit en, input bit pol);
    do_reset();
    step(req, 1, 8'h08, p);
    step(req, 1, 8'h0C, c);
    step(req, 1, 8'h28, ctl(1, en, pol));
    idle(req, 2 * (p + 1) + 1);
  endtask

  task automatic t_live_running();
    do_reset();
    step("R9", 1, 8'h08, 6);
    step("R9", 1, 8'h0C, 3);
    step("R9", 1, 8'h28, ctl(1, 1, 0));
    step("R9", 1, 8'h08, 2);
    step("R9", 1, 8'h0C, 1);
    idle("R9", 8);
    rd("R9", 8'h08, 6);
    rd("R9", 8'h0C, 3);
  endtask

  task automatic t_stage();
    do_reset();
    step("R10", 1, 8'h08, 5);
    step("R10", 1, 8'h0C, 2);
    step("R10", 1, 8'h28, ctl(1, 1, 0));
    idle("R10", 1);
    step("R10", 1, 8'h10, 3);
    step("R10", 1, 8'h14, 1);
    rd("R10", 8'h08, 5);
    rd("R10", 8'h10, 3);
    idle("R10", 12);
    rd("R10", 8'h08, 3);
    rd("R10", 8'h0C, 1);
    step("R10", 1, 8'h10, 4);
    idle("R10", 12);
    rd("R10", 8'h08, 4);
    rd("R10", 8'h14, 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_map();
    t_lanes();
    t_count();
    t_wave("R5", 7, 3, 1, 0);
    t_wave("R6", 7, 3, 0, 0);
    t_wave("R6", 5, 2, 0, 1);
    t_wave("R7", 7, 3, 1, 1);
    t_wave("R8", 4, 0, 1, 0);
    t_wave("R8", 4, 4, 1, 0);
    t_wave("R8", 4, 9, 1, 1);
    t_live_running();
    t_stage();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule